// File: doc/BRIEF.md
# Packet-Tick Phase Error Detector

This block sits at the front of a clock-recovery loop for isochronous audio. Two pulse streams arrive from outside the system clock domain: a strobe for every audio sample written into the receive FIFO, and the read clock that a digitally controlled oscillator generates for that FIFO. Each stream is synchronized and edge-detected, then divided down so that it produces one tick per packet period: the write side ticks once per received packet, and the read side ticks once every programmable number of read edges.

The block measures, in system clock cycles, the signed distance between each write tick and its matching read tick. It hands one error sample per packet period to the loop filter, with a one-cycle valid strobe. The write divider handles fractional sample rates. A packet normally carries a base number of samples, and the last packet of each programmable group carries one sample more. For example, a base of 44 and a group of 10 gives nine packets of 44 samples followed by one of 45, and a group of 0 gives a constant packet length such as 48. The read divider is held still until the first packet has been received. It starts counting from that moment, so the loop begins measuring near zero error. The first packet itself never yields a sample.

If a tick waits longer than the counter can express for its partner, the sample is clamped to the largest magnitude and flagged. The late partner is then discarded, so that pairing recovers on the next packet.

Top module: `tick_phase_detector`

## Requirements
- R1: After reset, `err_o` is 0 and `err_valid_o` and `err_ovf_o` are low.
- R2: The tick that ends the first write packet after reset produces no sample. Read-clock rising edges seen before that tick are ignored, and the read divider counts only edges that come after it.
- R3: Each sample equals the cycle of the read edge that completes a read tick minus the cycle of the write strobe edge that completes the matching packet. It is positive when the write side leads and 0 when both complete in the same cycle.
- R4: A write packet is `wr_base_i` strobe rising edges long. When `wr_group_i` is N (N>0), every N-th packet (positions N, 2N, ... counted from the first packet after reset) is one edge longer. N = 0 means every packet has the base length.
- R5: A read tick is produced on every `rd_div_i`-th read-clock rising edge (ratio 1..255) after the divider starts.
- R6: `err_valid_o` is a single-cycle pulse. It is visible after the fifth rising clock edge that samples the later of the two completing input edges, which is two system clocks after the later internal tick.
- R7: If the partner tick arrives no more than 32767 cycles after the leading one, the exact value is reported with `err_ovf_o` low. If it arrives later, a sample of +32767 (write led) or -32767 (read led) is reported with `err_ovf_o` high, at the time the exact value 32767 would have been reported.
- R8: After a saturated sample, the late partner tick yields no sample, and the next pair is measured normally.
- R9: Exactly one valid pulse is produced per matched tick pair.
- R10: `err_ovf_o` is high only together with `err_valid_o` on a saturated sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for counting |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_strobe_i | input | 1 | FIFO write strobe, one rising edge per sample (asynchronous) |
| rd_clk_i | input | 1 | FIFO read clock from the oscillator (asynchronous) |
| wr_base_i | input | DIV_W | Base number of samples per packet |
| wr_group_i | input | DIV_W | Group length for the one-longer packet, 0 = none |
| rd_div_i | input | DIV_W | Read edges per read tick |
| err_o | output | ERR_W | Signed phase error in system clock cycles |
| err_valid_o | output | 1 | One-cycle strobe marking a new error sample |
| err_ovf_o | output | 1 | Sample was clamped because the partner came too late |

## Verification
The hardest situation to reach is a lone tick whose partner never arrives within 32767 cycles, followed by the late partner and then a normal pair. The stimulus withholds one stream for more than 32767 cycles, first on the write side and then on the read side. It then releases the late burst and checks that nothing is reported before a fresh pair measures correctly. The exact boundary separation of 32767 is also driven. Re-phasing is exercised by sending read edges before the first packet: any miscount of those edges would shift every later error by whole read periods.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Pairing state of the phase counter
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,  // no tick outstanding
    PH_WR_LEAD = 3'd1,  // write tick seen, waiting for read tick
    PH_RD_LEAD = 3'd2,  // read tick seen, waiting for write tick
    PH_SKIP_WR = 3'd3,  // write-led sample clamped, discard late read tick
    PH_SKIP_RD = 3'd4   // read-led sample clamped, discard late write tick
  } ph_state_e;

endpackage

// File: rtl/tpd_edge_sync.sv
module tpd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tpd_tick_div.sv
module tpd_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             pulse_i,
  input  logic [DIV_W-1:0] base_i,
  input  logic [DIV_W-1:0] group_i,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);
  localparam logic [DIV_W:0]   ONE_X = (DIV_W+1)'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] pkt_q, pkt_d;
  logic             tick_q, tick_d;
  logic             grp_last;
  logic [DIV_W:0]   span;
  logic [DIV_W:0]   cnt_inc;
  logic             last;
  logic             adv;

  always_comb begin
    grp_last = (group_i != '0) && (pkt_q == group_i - ONE);
    span     = {1'b0, base_i} + {{DIV_W{1'b0}}, grp_last};
    cnt_inc  = {1'b0, cnt_q} + ONE_X;
    last     = (cnt_inc >= span);
    adv      = pulse_i & last & ~hold_i;

    cnt_d  = cnt_q;
    pkt_d  = pkt_q;
    tick_d = adv;
    if (hold_i) begin
      cnt_d = '0;
      pkt_d = '0;
    end else if (pulse_i) begin
      if (last) begin
        cnt_d = '0;
        pkt_d = (grp_last || (group_i == '0)) ? '0 : pkt_q + ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pkt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pkt_q  <= pkt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/tpd_phase_cnt.sv
module tpd_phase_cnt
  import tpd_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_tick_i,
  input  logic                    rd_tick_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_valid_o,
  output logic                    err_ovf_o
);

  localparam logic [ERR_W-1:0] LIMIT = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0] ONE_E = ERR_W'(1);

  ph_state_e               st_q, st_d;
  logic [ERR_W-1:0]        cnt_q, cnt_d;
  logic                    meas_vld_q, meas_vld_d;
  logic                    meas_ovf_q, meas_ovf_d;
  logic signed [ERR_W-1:0] meas_q, meas_d;
  logic signed [ERR_W-1:0] err_q;
  logic                    vld_q, ovf_q;

  // Pairing and counting
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    meas_vld_d = 1'b0;
    meas_ovf_d = 1'b0;
    meas_d     = meas_q;
    unique case (st_q)
      PH_IDLE: begin
        if (wr_tick_i && rd_tick_i) begin
          meas_vld_d = 1'b1;
          meas_d     = '0;
        end else if (wr_tick_i) begin
          st_d  = PH_WR_LEAD;
          cnt_d = ONE_E;
        end else if (rd_tick_i) begin
          st_d  = PH_RD_LEAD;
          cnt_d = ONE_E;
        end
      end
      PH_WR_LEAD: begin
        if (rd_tick_i) begin
          meas_vld_d = 1'b1;
          meas_d     = $signed(cnt_q);
          st_d       = PH_IDLE;
        end else if (cnt_q == LIMIT) begin
          meas_vld_d = 1'b1;
          meas_ovf_d = 1'b1;
          meas_d     = $signed(LIMIT);
          st_d       = PH_SKIP_WR;
        end else begin
          cnt_d = cnt_q + ONE_E;
        end
      end
      PH_RD_LEAD: begin
        if (wr_tick_i) begin
          meas_vld_d = 1'b1;
          meas_d     = -$signed(cnt_q);
          st_d       = PH_IDLE;
        end else if (cnt_q == LIMIT) begin
          meas_vld_d = 1'b1;
          meas_ovf_d = 1'b1;
          meas_d     = -$signed(LIMIT);
          st_d       = PH_SKIP_RD;
        end else begin
          cnt_d = cnt_q + ONE_E;
        end
      end
      PH_SKIP_WR: begin
        if (rd_tick_i) begin
          st_d = PH_IDLE;
        end else if (wr_tick_i) begin
          st_d  = PH_WR_LEAD;
          cnt_d = ONE_E;
        end
      end
      PH_SKIP_RD: begin
        if (wr_tick_i) begin
          st_d = PH_IDLE;
        end else if (rd_tick_i) begin
          st_d  = PH_RD_LEAD;
          cnt_d = ONE_E;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PH_IDLE;
      cnt_q      <= '0;
      meas_vld_q <= 1'b0;
      meas_ovf_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      meas_vld_q <= meas_vld_d;
      meas_ovf_q <= meas_ovf_d;
    end
  end

  // Measurement register, loaded only when a sample is formed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= '0;
    end else if (meas_vld_d) begin
      meas_q <= meas_d;
    end
  end

  // Output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (meas_vld_q) begin
        err_q <= meas_q;
      end
      vld_q <= meas_vld_q;
      ovf_q <= meas_vld_q & meas_ovf_q;
    end
  end

  assign err_o       = err_q;
  assign err_valid_o = vld_q;
  assign err_ovf_o   = ovf_q;

endmodule

// File: rtl/tick_phase_detector.sv
module tick_phase_detector
  import tpd_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int ERR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_strobe_i,
  input  logic                    rd_clk_i,
  input  logic [DIV_W-1:0]        wr_base_i,
  input  logic [DIV_W-1:0]        wr_group_i,
  input  logic [DIV_W-1:0]        rd_div_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_valid_o,
  output logic                    err_ovf_o
);

  localparam int NUM_CH = 2;  // channel 0: write strobe, channel 1: read clock

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe_q[1];

  // Input synchronization and edge detection
  logic [NUM_CH-1:0] raw_in;
  logic [NUM_CH-1:0] rise;
  assign raw_in = {rd_clk_i, wr_strobe_i};

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
      tpd_edge_sync #(
        .STAGES (SYNC_STAGES)
      ) u_sync (
        .clk     (clk),
        .rst_n   (srst_n),
        .async_i (raw_in[ch]),
        .rise_o  (rise[ch])
      );
    end
  endgenerate

  // Arming: the read side starts with the first completed packet
  logic armed_q, armed_d;
  logic wr_tick, rd_tick, wr_tick_m;

  always_comb begin
    armed_d = armed_q | wr_tick;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign wr_tick_m = wr_tick & armed_q;

  tpd_tick_div #(
    .DIV_W (DIV_W)
  ) u_wr_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .hold_i  (1'b0),
    .pulse_i (rise[0]),
    .base_i  (wr_base_i),
    .group_i (wr_group_i),
    .tick_o  (wr_tick)
  );

  tpd_tick_div #(
    .DIV_W (DIV_W)
  ) u_rd_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .hold_i  (~armed_q),
    .pulse_i (rise[1]),
    .base_i  (rd_div_i),
    .group_i ('0),
    .tick_o  (rd_tick)
  );

  tpd_phase_cnt #(
    .ERR_W (ERR_W)
  ) u_phase (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_tick_i   (wr_tick_m),
    .rd_tick_i   (rd_tick),
    .err_o       (err_o),
    .err_valid_o (err_valid_o),
    .err_ovf_o   (err_ovf_o)
  );

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
  parameter int ERR_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [ERR_W-1:0] err,
  input logic                    valid,
  input logic                    ovf,
  input logic                    armed,
  input logic                    wr_tick,
  input logic                    rd_tick
);

  localparam logic signed [ERR_W-1:0] POS_MAX = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic signed [ERR_W-1:0] NEG_MAX = -POS_MAX;
  localparam logic signed [ERR_W-1:0] NEG_EXT = {1'b1, {(ERR_W-1){1'b0}}};

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid)
    else $error("valid strobe longer than one cycle");

  p_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!valid && !rd_tick))
    else $error("activity before first packet");

  p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (valid && ((err == POS_MAX) || (err == NEG_MAX))))
    else $error("overflow flag without clamped sample");

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (err != NEG_EXT))
    else $error("error outside symmetric range");

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ovf) |-> $past(wr_tick || rd_tick, 2))
    else $error("sample not two cycles after a tick");

endmodule

bind tick_phase_detector tpd_checker #(.ERR_W(ERR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .err     (err_o),
  .valid   (err_valid_o),
  .ovf     (err_ovf_o),
  .armed   (armed_q),
  .wr_tick (wr_tick_m),
  .rd_tick (rd_tick)
);

// File: tb/tick_phase_detector_test.sv
module tick_phase_detector_test;

  localparam int LIM = 32767;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_s, rd_s;
  logic [7:0]        wr_base, wr_group, rd_div;
  logic signed [15:0] err;
  logic              valid, ovf;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int n_cap = 0;
  int cap_err [0:1023];
  int cap_ovf [0:1023];
  int cap_cyc [0:1023];
  int pkt_idx;

  tick_phase_detector uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_strobe_i (wr_s),
    .rd_clk_i    (rd_s),
    .wr_base_i   (wr_base),
    .wr_group_i  (wr_group),
    .rd_div_i    (rd_div),
    .err_o       (err),
    .err_valid_o (valid),
    .err_ovf_o   (ovf)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (valid && n_cap < 1024) begin
      cap_err[n_cap] = int'(err);
      cap_ovf[n_cap] = int'(ovf);
      cap_cyc[n_cap] = cyc;
      n_cap++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic at_cycle(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // n rising edges, 4 cycles apart, the last one driven at cycle end_c
  task automatic burst(input bit is_wr, input int n, input int end_c);
    int start;
    start = end_c - 4 * (n - 1);
    for (int i = 0; i < n; i++) begin
      at_cycle(start + 4 * i);
      if (is_wr) wr_s = 1'b1; else rd_s = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (is_wr) wr_s = 1'b0; else rd_s = 1'b0;
    end
  endtask

  function automatic int wlen(input int idx);
    int g;
    g = int'(wr_group);
    return int'(wr_base) + (((g != 0) && ((idx % g) == g - 1)) ? 1 : 0);
  endfunction

  task automatic do_reset(input int base, input int grp, input int rdv);
    rst_n = 1'b0;
    wr_s = 1'b0;
    rd_s = 1'b0;
    wr_base = 8'(base);
    wr_group = 8'(grp);
    rd_div = 8'(rdv);
    pkt_idx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(err == 0, "R1", "err after reset", int'(err), 0);
    check(!valid, "R1", "valid after reset", int'(valid), 0);
    check(!ovf, "R1", "ovf after reset", int'(ovf), 0);
  endtask

  // First packet after reset, with stray read edges before it
  task automatic first_packet();
    int n0, t;
    n0 = n_cap;
    burst(1'b0, 2, cyc + 10);
    t = cyc + 30;
    burst(1'b1, wlen(pkt_idx), t);
    pkt_idx++;
    at_cycle(t + 40);
    check(n_cap == n0, "R2", "samples from first packet", n_cap - n0, 0);
  endtask

  task automatic pair(input int d, input string req);
    int t, nw, nr, later, n0;
    nw = wlen(pkt_idx);
    nr = int'(rd_div);
    t = cyc + 50 + ((d < 0) ? -d : 0);
    later = (d > 0) ? t + d : t;
    n0 = n_cap;
    fork
      burst(1'b1, nw, t);
      burst(1'b0, nr, t + d);
    join
    pkt_idx++;
    at_cycle(later + 8);
    check(n_cap == n0 + 1, "R9", "pulses per pair", n_cap - n0, 1);
    if (n_cap > n0) begin
      check(cap_err[n0] == d, req, "error value", cap_err[n0], d);
      check(cap_ovf[n0] == 0, "R10", "ovf on normal sample", cap_ovf[n0], 0);
      check(cap_cyc[n0] == later + 5, "R6", "valid timing", cap_cyc[n0], later + 5);
    end
  endtask

  task automatic lone(input bit is_wr);
    int t, n0, expv;
    n0 = n_cap;
    t = cyc + 50;
    expv = is_wr ? LIM : -LIM;
    burst(is_wr, is_wr ? wlen(pkt_idx) : int'(rd_div), t);
    if (is_wr) pkt_idx++;
    at_cycle(t + LIM + 12);
    check(n_cap == n0 + 1, "R7", "clamped sample count", n_cap - n0, 1);
    if (n_cap > n0) begin
      check(cap_err[n0] == expv, "R7", "clamped value", cap_err[n0], expv);
      check(cap_ovf[n0] == 1, "R7", "ovf flag", cap_ovf[n0], 1);
      check(cap_cyc[n0] == t + LIM + 5, "R7", "clamp timing", cap_cyc[n0], t + LIM + 5);
    end
    // late partner is discarded
    n0 = n_cap;
    t = cyc + 30;
    burst(!is_wr, is_wr ? int'(rd_div) : wlen(pkt_idx), t);
    if (!is_wr) pkt_idx++;
    at_cycle(t + 30);
    check(n_cap == n0, "R8", "late partner ignored", n_cap - n0, 0);
  endtask

  task automatic run_all();
    // Fractional packet pattern: 4,4,5 edges; read ticks every 3 edges
    do_reset(4, 3, 3);
    first_packet();
    for (int d = -15; d <= 15; d++) begin
      pair(d, (wlen(pkt_idx) == 5) ? "R4" : "R3");
    end
    // Constant packet length, different read ratio
    do_reset(6, 0, 5);
    first_packet();
    for (int d = -6; d <= 6; d++) begin
      pair(d, ((d % 2) == 0) ? "R5" : "R4");
    end
    // Boundary and saturation
    pair(LIM, "R7");
    lone(1'b1);
    pair(7, "R8");
    lone(1'b0);
    pair(-3, "R8");
  endtask

  initial begin
    rst_n = 1'b0;
    wr_s = 1'b0;
    rd_s = 1'b0;
    wr_base = 8'd4;
    wr_group = 8'd0;
    rd_div = 8'd3;
    pkt_idx = 0;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule